// File: doc/BRIEF.md
# Two-Phase Interleaved PWM Generator

This block drives two switching channels from a single digital ramp counter. The second channel's ramp is shifted by half a switching period, so the two pulses alternate and the combined ripple runs at twice the channel rate. Each channel compares its own ramp against its own duty word. That duty word is a common duty command plus a signed correction, which steers the channel's current toward the mean of the two measured channel currents.

A mode input selects one of three output states: released (no drive), held low, or switching. Each output is presented as a drive-enable bit and a level bit, so a pad or driver stage can build a three-state pin from them. For each channel the block also emits a one-cycle strobe that marks when the external current measurement should be taken. The strobe is placed one third of a period into the channel's low interval. Current readings enter the block as unsigned digital words. The duty applied to a channel changes only at that channel's own period boundary.

Top module: `pwm2ph_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every drive-enable, level and strobe output is 0.
- R2: With mode 2'b00 or 2'b11 (released), from the cycle after the mode is applied both drive-enables, both levels and both strobes are 0.
- R3: With mode 2'b01 (held low), from the cycle after the mode is applied both drive-enables are 1 and both levels and strobes are 0.
- R4: With mode 2'b10 (switching), each channel is high for exactly D clock cycles out of every P. The pulse is a single run that starts at the channel's ramp origin. P is the period input, and a period below 4 acts as 4. A larger duty command gives a longer high time, never a shorter one.
- R5: Channel B's rising edge comes P - floor(P/2) cycles after channel A's rising edge.
- R6: Channel k's duty is D = base + ((avg - Ik) >>> gain), using signed arithmetic shift. avg is floor((Ia + Ib) / 2). A channel carrying more than the mean is therefore shortened, and one carrying less is lengthened.
- R7: D is clamped to the range 0 to P-1. A duty of 0 keeps the channel low for the whole period. A clamped duty of P-1 leaves exactly one low cycle.
- R8: A change to the duty command, the currents or the gain reaches a channel only at the last cycle of that channel's period. A pulse already in progress keeps its width.
- R9: In switching mode each channel emits exactly one single-cycle strobe per period, always while that channel is driven low. The strobe comes min(D + floor(P/3), P-1) - D cycles after the first low cycle, counting the first low cycle as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 00/11 released, 01 held low, 10 switching |
| period_i | input | CNT_W | Switching period in clock cycles |
| duty_i | input | CNT_W | Common duty command in clock cycles |
| isen_a_i | input | CUR_W | Sampled current of channel A, unsigned |
| isen_b_i | input | CUR_W | Sampled current of channel B, unsigned |
| gain_i | input | SH_W | Balance gain as a right-shift count |
| pwm_o | output | 2 | Output levels, bit 0 channel A, bit 1 channel B |
| pwm_oe_o | output | 2 | Output drive-enables |
| samp_o | output | 2 | Current-sample strobes |

## Verification
A counter or phase-offset error shows up at the ports within a single period. It appears as a wrong high count per period, or as a wrong spacing between the two channels' rising edges. A fault in the latched duty or in the balance arithmetic changes the measured pulse width from the next boundary onward. A duty that reloads in the middle of a cycle shortens the pulse already under way, which a mid-pulse change of the command exposes. Strobe placement errors appear as a strobe count other than one per period, or as an offset from the falling edge that does not match min(D + floor(P/3), P-1) - D.

// File: rtl/pwm2ph_pkg.sv
package pwm2ph_pkg;

   // number of interleaved channels; the averaging shift assumes a power of two
   localparam int NPH   = 2;
   // shortest period the time base accepts
   localparam int P_MIN = 4;

   typedef enum logic [1:0] {
      DRV_OFF     = 2'b00,
      DRV_LOW     = 2'b01,
      DRV_RUN     = 2'b10,
      DRV_OFF_ALT = 2'b11
   } drv_mode_e;

endpackage

// File: rtl/pwm2ph_timebase.sv
module pwm2ph_timebase
   import pwm2ph_pkg::*;
#(
   parameter int CNT_W = 10
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        run,
   input  logic [CNT_W-1:0]            period_i,
   output logic [CNT_W-1:0]            per_m1_o,
   output logic [CNT_W-1:0]            third_o,
   output logic [NPH-1:0][CNT_W-1:0]   ramp_o,
   output logic [NPH-1:0]              bound_o
);

   localparam int              EXT_W = CNT_W + 6;
   localparam logic [CNT_W-1:0] PMIN = CNT_W'(P_MIN);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] per_q;
   logic [CNT_W-1:0] third_q;
   logic [CNT_W-1:0] per_in;
   logic [CNT_W-1:0] per_m1;

   assign per_in = (period_i < PMIN) ? PMIN : period_i;
   assign per_m1 = per_q - 1'b1;

   // master counter; period and strobe offset are taken at the leading boundary
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         per_q   <= PMIN;
         third_q <= CNT_W'(P_MIN / 3);
      end else if (!run || (cnt_q == per_m1)) begin
         cnt_q   <= '0;
         per_q   <= per_in;
         third_q <= per_in / CNT_W'(3);
      end else begin
         cnt_q   <= cnt_q + 1'b1;
      end
   end

   assign per_m1_o = per_m1;
   assign third_o  = third_q;

   // per-channel ramp, offset by k/NPH of a period and wrapped into 0..P-1
   generate
      for (genvar k = 0; k < NPH; k++) begin : g_ph
         logic [CNT_W-1:0] off;
         logic [CNT_W:0]   sum;
         assign off = CNT_W'(({6'd0, per_q} * EXT_W'(k)) / EXT_W'(NPH));
         assign sum = {1'b0, cnt_q} + {1'b0, off};
         assign ramp_o[k]  = (sum >= {1'b0, per_q}) ? CNT_W'(sum - {1'b0, per_q})
                                                    : sum[CNT_W-1:0];
         assign bound_o[k] = (ramp_o[k] == per_m1);
      end
   endgenerate

   // R4
   ramp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !bound_o[0]) |=> (ramp_o[0] == $past(ramp_o[0]) + 1'b1));

   // R4
   ramp_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && bound_o[0]) |=> (ramp_o[0] == '0));

endmodule

// File: rtl/pwm2ph_balance.sv
module pwm2ph_balance
   import pwm2ph_pkg::*;
#(
   parameter int CNT_W   = 10,
   parameter int CUR_W   = 10,
   parameter int SH_W    = 4,
   parameter int AVG_RND = 0
) (
   input  logic [CNT_W-1:0]            base_i,
   input  logic [NPH-1:0][CUR_W-1:0]   isen_i,
   input  logic [SH_W-1:0]             gain_i,
   input  logic [CNT_W-1:0]            per_m1_i,
   output logic [NPH-1:0][CNT_W-1:0]   duty_o
);

   localparam int AVG_SH = $clog2(NPH);
   localparam int SUM_W  = CUR_W + AVG_SH;
   localparam int SW     = ((CNT_W > CUR_W) ? CNT_W : CUR_W) + 2;

   logic [SUM_W-1:0] isum;
   logic [CUR_W-1:0] iavg;

   always_comb begin
      isum = '0;
      for (int k = 0; k < NPH; k++) begin
         isum = isum + SUM_W'(isen_i[k]);
      end
   end

   // mean of the channel currents: truncating or rounding variant
   generate
      if (AVG_RND != 0) begin : g_avg_round
         assign iavg = CUR_W'((isum + 1'b1) >> AVG_SH);
      end else begin : g_avg_floor
         assign iavg = CUR_W'(isum >> AVG_SH);
      end
   endgenerate

   generate
      for (genvar k = 0; k < NPH; k++) begin : g_ch
         logic signed [SW-1:0] diff;
         logic signed [SW-1:0] corr;
         logic signed [SW-1:0] tot;
         assign diff = $signed(SW'(iavg)) - $signed(SW'(isen_i[k]));
         assign corr = diff >>> gain_i;
         assign tot  = $signed(SW'(base_i)) + corr;
         assign duty_o[k] = (tot < 0)                        ? '0       :
                            (tot > $signed(SW'(per_m1_i)))   ? per_m1_i :
                                                               tot[CNT_W-1:0];
      end
   endgenerate

endmodule

// File: rtl/pwm2ph_chan.sv
module pwm2ph_chan
   import pwm2ph_pkg::*;
#(
   parameter int CNT_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  drv_mode_e         mode_i,
   input  logic [CNT_W-1:0]  ramp_i,
   input  logic              bound_i,
   input  logic [CNT_W-1:0]  duty_i,
   input  logic [CNT_W-1:0]  third_i,
   input  logic [CNT_W-1:0]  per_m1_i,
   output logic              lvl_o,
   output logic              oe_o,
   output logic              stb_o
);

   logic [CNT_W-1:0] d_q;
   logic [CNT_W:0]   tgt;
   logic [CNT_W-1:0] tgt_c;

   // duty is held for a full cycle; reloaded only at this channel's boundary
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         d_q <= '0;
      end else if ((mode_i != DRV_RUN) || bound_i) begin
         d_q <= duty_i;
      end
   end

   // strobe point: a third of a period into the low part, kept inside the cycle
   assign tgt   = {1'b0, d_q} + {1'b0, third_i};
   assign tgt_c = (tgt > {1'b0, per_m1_i}) ? per_m1_i : tgt[CNT_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe_o  <= 1'b0;
         lvl_o <= 1'b0;
         stb_o <= 1'b0;
      end else begin
         unique case (mode_i)
            DRV_RUN: begin
               oe_o  <= 1'b1;
               lvl_o <= (ramp_i < d_q);
               stb_o <= (ramp_i == tgt_c);
            end
            DRV_LOW: begin
               oe_o  <= 1'b1;
               lvl_o <= 1'b0;
               stb_o <= 1'b0;
            end
            default: begin
               oe_o  <= 1'b0;
               lvl_o <= 1'b0;
               stb_o <= 1'b0;
            end
         endcase
      end
   end

   // R2
   released_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_i == DRV_OFF) || (mode_i == DRV_OFF_ALT)) |=> (!oe_o && !lvl_o && !stb_o));

   // R3
   held_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == DRV_LOW) |=> (oe_o && !lvl_o && !stb_o));

   // R9
   stb_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stb_o |-> (oe_o && !lvl_o));

   // R8
   duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_i == DRV_RUN) && !bound_i) |=> $stable(d_q));

endmodule

// File: rtl/pwm2ph_gen.sv
module pwm2ph_gen
   import pwm2ph_pkg::*;
#(
   parameter int CNT_W   = 10,
   parameter int CUR_W   = 10,
   parameter int SH_W    = 4,
   parameter int AVG_RND = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode_i,
   input  logic [CNT_W-1:0]  period_i,
   input  logic [CNT_W-1:0]  duty_i,
   input  logic [CUR_W-1:0]  isen_a_i,
   input  logic [CUR_W-1:0]  isen_b_i,
   input  logic [SH_W-1:0]   gain_i,
   output logic [1:0]        pwm_o,
   output logic [1:0]        pwm_oe_o,
   output logic [1:0]        samp_o
);

   // elaboration-time parameter checks
   generate
      if (CNT_W < 3 || CNT_W > 16) begin : g_bad_cnt
         $error("pwm2ph_gen: CNT_W must lie in 3..16");
      end
      if (CUR_W < 2 || CUR_W > 16) begin : g_bad_cur
         $error("pwm2ph_gen: CUR_W must lie in 2..16");
      end
      if (SH_W < 1 || SH_W > 5) begin : g_bad_sh
         $error("pwm2ph_gen: SH_W must lie in 1..5");
      end
      if (AVG_RND != 0 && AVG_RND != 1) begin : g_bad_rnd
         $error("pwm2ph_gen: AVG_RND must be 0 or 1");
      end
      if (NPH != 2) begin : g_bad_nph
         $error("pwm2ph_gen: port set is built for two channels");
      end
   endgenerate

   drv_mode_e                   mode_e;
   logic                        run;
   logic [CNT_W-1:0]            per_m1;
   logic [CNT_W-1:0]            third;
   logic [NPH-1:0][CNT_W-1:0]   ramp;
   logic [NPH-1:0]              bound;
   logic [NPH-1:0][CUR_W-1:0]   isen_v;
   logic [NPH-1:0][CNT_W-1:0]   duty_v;

   assign mode_e    = drv_mode_e'(mode_i);
   assign run       = (mode_e == DRV_RUN);
   assign isen_v[0] = isen_a_i;
   assign isen_v[1] = isen_b_i;

   pwm2ph_timebase #(
      .CNT_W    (CNT_W)
   ) u_tb (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .period_i (period_i),
      .per_m1_o (per_m1),
      .third_o  (third),
      .ramp_o   (ramp),
      .bound_o  (bound)
   );

   pwm2ph_balance #(
      .CNT_W    (CNT_W),
      .CUR_W    (CUR_W),
      .SH_W     (SH_W),
      .AVG_RND  (AVG_RND)
   ) u_bal (
      .base_i   (duty_i),
      .isen_i   (isen_v),
      .gain_i   (gain_i),
      .per_m1_i (per_m1),
      .duty_o   (duty_v)
   );

   generate
      for (genvar k = 0; k < NPH; k++) begin : g_ch
         pwm2ph_chan #(
            .CNT_W    (CNT_W)
         ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode_i   (mode_e),
            .ramp_i   (ramp[k]),
            .bound_i  (bound[k]),
            .duty_i   (duty_v[k]),
            .third_i  (third),
            .per_m1_i (per_m1),
            .lvl_o    (pwm_o[k]),
            .oe_o     (pwm_oe_o[k]),
            .stb_o    (samp_o[k])
         );
      end
   endgenerate

   // R5
   antiphase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && bound[0]) |-> (ramp[1] == CNT_W'(({1'b0, per_m1} + 1'b1) >> 1) - 1'b1));

endmodule

// File: tb/pwm2ph_gen_tb.sv
module pwm2ph_gen_tb;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] mode;
   logic [9:0] period;
   logic [9:0] duty;
   logic [9:0] ia;
   logic [9:0] ib;
   logic [3:0] gain;
   logic [1:0] pwm;
   logic [1:0] oe;
   logic [1:0] samp;

   int nchk  = 0;
   int nfail = 0;

   always #4 clk = ~clk;

   pwm2ph_gen u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_i   (mode),
      .period_i (period),
      .duty_i   (duty),
      .isen_a_i (ia),
      .isen_b_i (ib),
      .gain_i   (gain),
      .pwm_o    (pwm),
      .pwm_oe_o (oe),
      .samp_o   (samp)
   );

   // port monitor, sampled on the falling edge
   int cyc = 0;
   bit meas = 1'b0;
   int hc[2], sc[2], soff[2], hrun[2], lowrun[2], wlast[2], fcnt[2], rcnt[2], trise[2];
   bit prev[2];
   int gap = -1;

   initial begin
      for (int k = 0; k < 2; k++) begin
         hc[k] = 0; sc[k] = 0; soff[k] = -1; hrun[k] = 0; lowrun[k] = 0;
         wlast[k] = 0; fcnt[k] = 0; rcnt[k] = 0; trise[k] = 0; prev[k] = 1'b0;
      end
   end

   always @(negedge clk) begin
      cyc++;
      for (int k = 0; k < 2; k++) begin
         if (pwm[k]) begin
            if (!prev[k]) begin
               rcnt[k]++;
               trise[k] = cyc;
               if (k == 1) gap = cyc - trise[0];
               hrun[k] = 1;
            end else begin
               hrun[k]++;
            end
         end else begin
            if (prev[k]) begin
               wlast[k] = hrun[k];
               fcnt[k]++;
               lowrun[k] = 0;
            end else begin
               lowrun[k]++;
            end
         end
         if (meas) begin
            if (pwm[k]) hc[k]++;
            if (samp[k]) begin
               sc[k]++;
               soff[k] = lowrun[k];
            end
         end
         prev[k] = pwm[k];
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int eff_p(input int p);
      return (p < 4) ? 4 : p;
   endfunction

   // R6 / R7 reference: mean, signed shift correction, clamp
   function automatic int exp_duty(input int k, input int p, input int base,
                                   input int a, input int b, input int g);
      int pe = eff_p(p);
      int avg = (a + b) / 2;
      int s = (k == 0) ? a : b;
      int c = (avg - s) >>> g;
      int t = base + c;
      if (t < 0) t = 0;
      if (t > pe - 1) t = pe - 1;
      return t;
   endfunction

   task automatic run_case(input int p, input int base, input int a, input int b, input int g);
      int pe = eff_p(p);
      int d[2];
      @(posedge clk); #1;
      mode = 2'b00; period = 10'(p); duty = 10'(base); ia = 10'(a); ib = 10'(b); gain = 4'(g);
      repeat (3) @(posedge clk);
      #1 mode = 2'b10;
      repeat (3 * pe + 4) @(posedge clk);
      #1;
      for (int k = 0; k < 2; k++) begin hc[k] = 0; sc[k] = 0; soff[k] = -1; end
      meas = 1'b1;
      repeat (pe) @(posedge clk);
      #1 meas = 1'b0;
      for (int k = 0; k < 2; k++) begin
         d[k] = exp_duty(k, p, base, a, b, g);
         // R4 R6 R7: high cycles per period
         chk(hc[k] == d[k], $sformatf("R4/R6/R7 high count ch%0d p=%0d", k, p), hc[k], d[k]);
         // R9: one strobe per period
         chk(sc[k] == 1, $sformatf("R9 strobe count ch%0d", k), sc[k], 1);
         if (d[k] > 0) begin
            int eo = ((d[k] + pe / 3) > (pe - 1) ? (pe - 1) : (d[k] + pe / 3)) - d[k];
            chk(soff[k] == eo, $sformatf("R9 strobe offset ch%0d", k), soff[k], eo);
         end
      end
      if (d[0] > 0 && d[1] > 0) begin
         // R5: lagging rising edge
         chk(gap == pe - pe / 2, "R5 phase offset", gap, pe - pe / 2);
      end
   endtask

   task automatic chk_static(input logic [1:0] exp_oe, input string req);
      for (int i = 0; i < 4; i++) begin
         @(posedge clk); #1;
         chk(oe == exp_oe && pwm == 2'b00 && samp == 2'b00, req,
             int'({oe, pwm, samp}), int'({exp_oe, 4'b0000}));
      end
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin
      int seed;
      int r0, f0;
      rst_n = 1'b0; mode = 2'b10; period = 10'd40; duty = 10'd20;
      ia = 10'd0; ib = 10'd0; gain = 4'd0;
      repeat (3) @(posedge clk);
      #1;
      // R1: outputs quiet in reset
      chk(oe == 2'b00 && pwm == 2'b00 && samp == 2'b00, "R1 in reset",
          int'({oe, pwm, samp}), 0);
      mode = 2'b00;
      rst_n = 1'b1;
      @(posedge clk); #1;
      chk(oe == 2'b00 && pwm == 2'b00 && samp == 2'b00, "R1 after release",
          int'({oe, pwm, samp}), 0);

      // directed cases
      run_case(40, 10, 100, 100, 0);   // R4 basic
      run_case(40, 20, 100, 100, 0);   // R4 longer command
      run_case(41, 15, 200, 200, 0);   // R5 odd period
      run_case(50, 10, 0, 400, 0);     // R7 clamp both ends
      run_case(50, 25, 300, 100, 2);   // R6 shifted correction + R7
      run_case(60, 30, 120, 80, 1);    // R6 imbalance, no clamp
      run_case(60, 0, 5, 5, 0);        // R7 zero duty
      run_case(3, 2, 7, 7, 0);         // R4 short period acts as 4
      run_case(30, 29, 50, 50, 0);     // R7 top of range, single low cycle

      // R3: held low
      @(posedge clk); #1 mode = 2'b01;
      @(posedge clk);
      chk_static(2'b11, "R3 held low");
      // R2: released, both encodings
      #1 mode = 2'b00;
      @(posedge clk);
      chk_static(2'b00, "R2 released 00");
      run_case(40, 10, 100, 100, 0);
      @(posedge clk); #1 mode = 2'b11;
      @(posedge clk);
      chk_static(2'b00, "R2 released 11");

      // R8: duty change inside a pulse does not cut it short
      run_case(40, 30, 100, 100, 0);
      r0 = rcnt[0];
      while (rcnt[0] == r0) @(posedge clk);
      #1 duty = 10'd5;
      f0 = fcnt[0];
      while (fcnt[0] == f0) @(posedge clk);
      #1;
      chk(wlast[0] == 30, "R8 pulse in progress kept", wlast[0], 30);
      f0 = fcnt[0];
      while (fcnt[0] == f0) @(posedge clk);
      #1;
      chk(wlast[0] == 5, "R8 new duty from next cycle", wlast[0], 5);

      // constrained random, fixed seed
      seed = $urandom(32'd20240);
      for (int i = 0; i < 24; i++) begin
         int p = 4 + int'($urandom % 150);
         int base = int'($urandom % (p + 16));
         int a = int'($urandom % 1024);
         int b = int'($urandom % 1024);
         int g = int'($urandom % 6);
         run_case(p, base, a, b, g);   // R4 R5 R6 R7 R9
      end

      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

endmodule